// File: doc/BRIEF.md
# Tick Compare Timer

A free-running cycle counter with a compare register that raises a soft interrupt bit and a one-cycle wake pulse when the count reaches the compare value. The counter advances by one on every cycle in which `tick_en` is high (nominally a 100 MHz tick) and wraps modulo 2^63. Software reaches it through three strobes that share one 64-bit data bus: load the count, load the compare value, and sample the count.

The top bit of every written word is a control flag, not part of the value. Both writes copy it into a single disable flag, and a count read returns it in the top bit. Parameter `DIS_MODE` sets what the flag does. In `STOP_COUNT` it freezes the counter and blocks interrupts. In `MASK_IRQ` the counter keeps running and only the interrupt is blocked. Parameter `SOFT_SEL` sets which of the two soft interrupt bits the instance drives: bit 0 is the tick-match bit and bit 1 is the system-tick-match bit.

A match is one-shot. A compare value of zero never matches. A compare value written at or below the count fires on the next tick and does not wait for the counter to wrap.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the disable flag is set, the count is zero, `soft_bits` and `wake` are low, and a count read returns 0x8000_0000_0000_0000.
- R2: A count write loads `wr_data[62:0]` into the count and `wr_data[63]` into the disable flag. A read strobe makes `rd_data` show the count in bits 62:0 and the disable flag in bit 63, valid from the cycle after the strobe.
- R3: Each enabled cycle with `tick_en` high adds one to the count, modulo 2^63. Without a tick or a write the count holds.
- R4: A limit write copies `wr_data[63]` into the disable flag and arms a match on `wr_data[62:0]`. The first tick that brings the count to that value sets the soft bit and makes `wake` high for exactly one cycle, both visible in the cycle after that tick's edge.
- R5: A limit write with bits 62:0 all zero arms nothing and cancels any armed match.
- R6: A compare value at or below the count (after that cycle's update) fires on the next tick.
- R7: While the disable flag is set, a limit write arms nothing. An armed match that is reached while the flag is set is dropped and sets neither the soft bit nor `wake`.
- R8: After a match fires, no further match fires until another limit write.
- R9: The soft bit stays set until `soft_clr` is high. Clearing it leaves the count unchanged.
- R10: `SOFT_SEL` = 0 drives only `soft_bits[0]` and `SOFT_SEL` = 1 drives only `soft_bits[1]`. The other bit stays 0.
- R11: With `DIS_MODE` = `STOP_COUNT` the disable flag freezes the count. With `MASK_IRQ` the count keeps advancing while the flag is set.
- R12: A count write in the same cycle as a tick wins: the count becomes exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the count by one this cycle |
| wr_count | input | 1 | Load count and disable flag from `wr_data` |
| wr_limit | input | 1 | Load compare value and disable flag from `wr_data` |
| wr_data | input | 64 | Write data; bit 63 is the disable flag |
| rd_count | input | 1 | Sample the count view into `rd_data` |
| rd_data | output | 64 | Sampled count; bit 63 is the disable flag |
| soft_clr | input | 1 | Clear the soft interrupt bit |
| soft_bits | output | 2 | Soft interrupt bits: [0] tick match, [1] system-tick match |
| wake | output | 1 | One-cycle pulse on each delivered match |

## Verification
The bench drives the same stimulus into two instances. The first is built with `SOFT_SEL` = 0 and `DIS_MODE` = `STOP_COUNT`, the second with `SOFT_SEL` = 1 and `DIS_MODE` = `MASK_IRQ`. With both variants side by side, one disable write leaves the count frozen in the first instance and running in the second. This lets the bench check a reached match that must be dropped and watch it land on a different soft bit in each instance. The 63-bit default width is kept, so the wrap check loads a count two below the top and ticks across zero.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

  typedef enum logic {
    SOFT_TICK    = 1'b0,
    SOFT_SYSTICK = 1'b1
  } soft_sel_e;

  typedef enum logic {
    STOP_COUNT = 1'b0,
    MASK_IRQ   = 1'b1
  } dis_mode_e;

  // Value mask for a w-bit count held in a 64-bit word.
  function automatic logic [63:0] val_mask(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  // Increment modulo 2^w.
  function automatic logic [63:0] wrap_inc(input logic [63:0] v, input int w);
    return (v + 64'd1) & val_mask(w);
  endfunction

  // A compare value already reached or passed counts as late.
  function automatic logic is_late(input logic [63:0] cmp, input logic [63:0] cnt);
    return cmp <= cnt;
  endfunction

  // Software view of the count: flag sits just above the value.
  function automatic logic [63:0] read_view(input logic flag, input logic [63:0] v, input int w);
    return (v & val_mask(w)) | (64'(flag) << w);
  endfunction

endpackage

// File: rtl/tick_cmp_counter.sv
module tick_cmp_counter
  import tick_cmp_pkg::*;
#(
  parameter int        VAL_W    = 63,
  parameter dis_mode_e DIS_MODE = STOP_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_count,
  input  logic             wr_limit,
  input  logic             wr_flag,
  input  logic [VAL_W-1:0] wr_val,
  output logic [VAL_W-1:0] cnt_q,
  output logic [VAL_W-1:0] cnt_d,
  output logic             dis_q,
  output logic             dis_d,
  output logic             step
);

  logic        run_ok;
  logic [63:0] inc_w;

  always_comb begin
    dis_d = dis_q;
    if (wr_count || wr_limit) dis_d = wr_flag;
  end

  always_comb begin
    run_ok = (DIS_MODE == MASK_IRQ) || !dis_q;
    step   = tick_en && run_ok && !wr_count;
    inc_w  = wrap_inc(64'(cnt_q), VAL_W);
    if (wr_count)  cnt_d = wr_val;
    else if (step) cnt_d = inc_w[VAL_W-1:0];
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dis_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dis_q <= dis_d;
    end
  end

endmodule

// File: rtl/tick_cmp_match.sv
module tick_cmp_match
  import tick_cmp_pkg::*;
#(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_limit,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             dis_d,
  input  logic [VAL_W-1:0] cnt_d,
  output logic             hit,
  output logic             armed_q
);

  logic [VAL_W-1:0] cmp_q;
  logic             late_q;
  logic             ld_arm;

  assign ld_arm = (wr_val != '0) && !dis_d;
  assign hit    = armed_q && step && !wr_limit && (late_q || (cnt_d == cmp_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      late_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_limit) begin
      cmp_q   <= wr_val;
      late_q  <= is_late(64'(wr_val), 64'(cnt_d));
      armed_q <= ld_arm;
    end else if (hit) begin
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_cmp_irq.sv
module tick_cmp_irq
  import tick_cmp_pkg::*;
#(
  parameter soft_sel_e SOFT_SEL = SOFT_TICK
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       dis_q,
  input  logic       soft_clr,
  output logic       fire,
  output logic [1:0] soft_bits,
  output logic       wake
);

  logic soft_q;

  assign fire = hit && !dis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      wake   <= 1'b0;
    end else begin
      wake <= fire;
      if (fire)          soft_q <= 1'b1;
      else if (soft_clr) soft_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_bit
    if (i == int'(SOFT_SEL)) begin : g_drv
      assign soft_bits[i] = soft_q;
    end else begin : g_zero
      assign soft_bits[i] = 1'b0;
    end
  end

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int        VAL_W    = 63,
  parameter soft_sel_e SOFT_SEL = SOFT_TICK,
  parameter dis_mode_e DIS_MODE = STOP_COUNT,
  localparam int       REG_W    = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_count,
  input  logic             wr_limit,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_count,
  output logic [REG_W-1:0] rd_data,
  input  logic             soft_clr,
  output logic [1:0]       soft_bits,
  output logic             wake
);

  logic [VAL_W-1:0] cnt_q;
  logic [VAL_W-1:0] cnt_d;
  logic             dis_q;
  logic             dis_d;
  logic             step;
  logic             hit;
  logic             fire;
  logic             armed_q;
  logic [63:0]      view_w;

  tick_cmp_counter #(.VAL_W(VAL_W), .DIS_MODE(DIS_MODE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_count (wr_count),
    .wr_limit (wr_limit),
    .wr_flag  (wr_data[REG_W-1]),
    .wr_val   (wr_data[VAL_W-1:0]),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .dis_q    (dis_q),
    .dis_d    (dis_d),
    .step     (step)
  );

  tick_cmp_match #(.VAL_W(VAL_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wr_limit (wr_limit),
    .wr_val   (wr_data[VAL_W-1:0]),
    .dis_d    (dis_d),
    .cnt_d    (cnt_d),
    .hit      (hit),
    .armed_q  (armed_q)
  );

  tick_cmp_irq #(.SOFT_SEL(SOFT_SEL)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .dis_q     (dis_q),
    .soft_clr  (soft_clr),
    .fire      (fire),
    .soft_bits (soft_bits),
    .wake      (wake)
  );

  assign view_w = read_view(dis_q, 64'(cnt_q), VAL_W);

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_data <= '0;
    else if (rd_count) rd_data <= view_w[REG_W-1:0];
  end

endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk
  import tick_cmp_pkg::*;
#(
  parameter int        VAL_W    = 63,
  parameter soft_sel_e SOFT_SEL = SOFT_TICK,
  parameter dis_mode_e DIS_MODE = STOP_COUNT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             wr_count,
  input logic             wr_limit,
  input logic [VAL_W:0]   wr_data,
  input logic             soft_clr,
  input logic [1:0]       soft_bits,
  input logic             wake,
  input logic             step,
  input logic             dis_q,
  input logic             armed_q,
  input logic [VAL_W-1:0] cnt_q
);

  localparam int OTHER = (SOFT_SEL == SOFT_TICK) ? 1 : 0;

  // R4: wake is a single-cycle pulse
  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R3: every step advances the count by exactly one
  p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == VAL_W'($past(cnt_q) + 1'b1));

  // R3: no tick and no write keeps the count
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_count) |=> $stable(cnt_q));

  // R5: a zero compare value leaves nothing armed
  p_zero_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_limit && wr_data[VAL_W-1:0] == '0) |=> !armed_q);

  // R7: a disabled limit write arms nothing
  p_dis_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_limit && wr_data[VAL_W]) |=> !armed_q);

  // R7: while disabled and not rewritten, no wake follows
  p_dis_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !wr_count && !wr_limit) |=> !wake);

  // R9: soft bit held without a clear
  p_soft_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_bits != 2'b00 && !soft_clr) |=> soft_bits == $past(soft_bits));

  // R10: the unselected soft bit never rises
  p_soft_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_bits[OTHER]);

  if (DIS_MODE == STOP_COUNT) begin : g_stop
    // R11: frozen count while disabled
    p_count_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q && !wr_count) |=> $stable(cnt_q));
  end

endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(
  .VAL_W(VAL_W), .SOFT_SEL(SOFT_SEL), .DIS_MODE(DIS_MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .wr_count  (wr_count),
  .wr_limit  (wr_limit),
  .wr_data   (wr_data),
  .soft_clr  (soft_clr),
  .soft_bits (soft_bits),
  .wake      (wake),
  .step      (step),
  .dis_q     (dis_q),
  .armed_q   (armed_q),
  .cnt_q     (cnt_q)
);

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
  import tick_cmp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_count = 1'b0;
  logic        wr_limit = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_count = 1'b0;
  logic        soft_clr = 1'b0;
  logic [63:0] rd_a, rd_b;
  logic [1:0]  soft_a, soft_b;
  logic        wake_a, wake_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  tick_cmp_timer #(.SOFT_SEL(SOFT_TICK), .DIS_MODE(STOP_COUNT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_count(wr_count),
    .wr_limit(wr_limit), .wr_data(wr_data), .rd_count(rd_count),
    .rd_data(rd_a), .soft_clr(soft_clr), .soft_bits(soft_a), .wake(wake_a));

  tick_cmp_timer #(.SOFT_SEL(SOFT_SYSTICK), .DIS_MODE(MASK_IRQ)) uut_b (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_count(wr_count),
    .wr_limit(wr_limit), .wr_data(wr_data), .rd_count(rd_count),
    .rd_data(rd_b), .soft_clr(soft_clr), .soft_bits(soft_b), .wake(wake_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr_count(input logic [63:0] v);
    @(negedge clk); wr_count = 1'b1; wr_data = v;
    @(negedge clk); wr_count = 1'b0;
  endtask

  task automatic do_wr_limit(input logic [63:0] v);
    @(negedge clk); wr_limit = 1'b1; wr_data = v;
    @(negedge clk); wr_limit = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic do_read;
    @(negedge clk); rd_count = 1'b1;
    @(negedge clk); rd_count = 1'b0;
  endtask

  task automatic do_clear;
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 soft_a", 64'(soft_a), 0);
    chk("R1 soft_b", 64'(soft_b), 0);
    chk("R1 wake", 64'({wake_a, wake_b}), 0);
    do_read;
    chk("R1 read_a", rd_a, FLAG);
    chk("R1 read_b", rd_b, FLAG);
  endtask

  task automatic t_count_rw;
    do_wr_count(64'd100);
    do_read;
    chk("R2 read enabled", rd_a, 64'd100);
    chk("R2 read enabled b", rd_b, 64'd100);
    do_wr_count(FLAG | 64'd5);
    do_read;
    chk("R2 read flagged", rd_a, FLAG | 64'd5);
    do_wr_count(64'd10);
    run_ticks(7);
    do_read;
    chk("R3 seven ticks", rd_a, 64'd17);
    chk("R3 seven ticks b", rd_b, 64'd17);
    do_wr_count(64'h7FFF_FFFF_FFFF_FFFE);
    run_ticks(3);
    do_read;
    chk("R3 wrap", rd_a, 64'd1);
  endtask

  task automatic t_match;
    do_wr_count(64'd0);
    do_wr_limit(64'd5);
    run_ticks(4);
    chk("R4 before match", 64'({soft_a, soft_b}), 0);
    run_ticks(1);
    chk("R4 R10 soft_a", 64'(soft_a), 64'd1);
    chk("R4 R10 soft_b", 64'(soft_b), 64'd2);
    chk("R4 wake on", 64'({wake_a, wake_b}), 64'd3);
    @(negedge clk);
    chk("R4 wake off", 64'({wake_a, wake_b}), 0);
    run_ticks(3);
    chk("R8 R9 soft held", 64'({soft_a, soft_b}), 64'b0110);
    chk("R8 no refire", 64'({wake_a, wake_b}), 0);
    do_clear;
    chk("R9 cleared", 64'({soft_a, soft_b}), 0);
    do_read;
    chk("R9 count kept", rd_a, 64'd8);
  endtask

  task automatic t_late;
    do_wr_limit(64'd3);
    run_ticks(1);
    chk("R6 below fires", 64'({soft_a, soft_b}), 64'b0110);
    chk("R6 below wake", 64'({wake_a, wake_b}), 64'd3);
    do_clear;
    do_wr_limit(64'd9);
    run_ticks(1);
    chk("R6 equal fires", 64'({soft_a, soft_b}), 64'b0110);
    do_clear;
  endtask

  task automatic t_zero;
    do_wr_limit(64'd20);
    do_wr_limit(64'd0);
    run_ticks(15);
    chk("R5 zero cancels", 64'({soft_a, soft_b}), 0);
    do_read;
    chk("R5 count", rd_a, 64'd25);
  endtask

  task automatic t_disable;
    do_wr_limit(FLAG | 64'd30);
    run_ticks(5);
    chk("R7 no arm", 64'({soft_a, soft_b}), 0);
    do_read;
    chk("R11 stop mode frozen", rd_a, FLAG | 64'd25);
    chk("R11 mask mode runs", rd_b, FLAG | 64'd30);
    do_wr_count(64'd0);
    do_wr_limit(64'd4);
    run_ticks(2);
    do_wr_count(FLAG | 64'd2);
    run_ticks(4);
    chk("R7 reached while disabled", 64'({soft_a, soft_b}), 0);
    do_read;
    chk("R11 frozen a", rd_a, FLAG | 64'd2);
    chk("R11 running b", rd_b, FLAG | 64'd6);
    do_wr_count(64'd0);
    run_ticks(6);
    chk("R7 dropped match in b, kept in a", 64'({soft_a, soft_b}), 64'b0100);
    do_clear;
  endtask

  task automatic t_priority;
    @(negedge clk); tick_en = 1'b1; wr_count = 1'b1; wr_data = 64'd50;
    @(negedge clk); tick_en = 1'b0; wr_count = 1'b0;
    do_read;
    chk("R12 write beats tick", rd_a, 64'd50);
    chk("R12 write beats tick b", rd_b, 64'd50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count_rw;
    t_match;
    t_late;
    t_zero;
    t_disable;
    t_priority;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule